// File: doc/BRIEF.md
# Video DRAM Access Arbiter

This block lets one bank of dual-ported video DRAM serve three requesters. The requesters are a host CPU, a video timing generator and an internal refresh timer. The video timing generator sends a pulse once per scan line to ask for a row-to-shift-register transfer. The block grants one requester at a time. It drives the multiplexed DRAM address and the RAS, CAS, WE and DT/OE strobes from a six-state sequencer: idle, row, column, transfer, refresh and precharge.

Refresh is RAS-only. The refresh row counter is placed on the address bus and then advanced by one. The refresh timer raises a refresh request every `REF_INTERVAL` clocks. A transfer cycle is marked by holding DT/OE low at the moment RAS falls. The requester address is captured at the grant edge, so the CPU may change its address inputs while the cycle runs. The video source sets the line rate; the block does not assume a fixed line period. Every access ends with a precharge interval that the block times itself. A request that arrives during that interval is kept and served afterwards.

Top module: `vram_arbiter`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `ras_n`, `cas_n`, `we_n` and `dt_oe_n` are high and both acknowledges are low.
- R2: When more than one request is pending at the grant decision, refresh wins over a pending line transfer, and a line transfer wins over the CPU.
- R3: A CPU access holds `ras_n` low for `T_RCD` cycles with the row on `dram_addr`, then for `T_CAS` further cycles with `cas_n` also low and the column on `dram_addr`. Address bits [2*MA_W-1:MA_W] are the row and bits [MA_W-1:0] are the column. `cpu_ack` is high for exactly the first RAS-low cycle.
- R4: A transfer cycle has the same row and column phases as a CPU access. `dt_oe_n` is low in the cycle RAS falls and stays low throughout RAS-low. `we_n` stays high. `xfer_ack` is high for the first RAS-low cycle.
- R5: Refresh is RAS-only: `cas_n`, `we_n` and `dt_oe_n` stay high, `ras_n` is low for `T_REF_RAS` cycles, and `dram_addr` carries the refresh row. The refresh row starts at 0 and increases by 1, modulo 2^MA_W, after each refresh. A refresh becomes pending every `REF_INTERVAL` cycles.
- R6: After `ras_n` rises it stays high for at least `T_RP` cycles, whatever the requesters do.
- R7: Changing `cpu_addr`, `cpu_we` or `xfer_addr` after the acknowledge does not change the row, column or write type of the cycle in progress.
- R8: A one-cycle `xfer_req` pulse that arrives while the bank is busy or precharging is kept and served exactly once. No `xfer_ack` occurs without a pulse before it.
- R9: `cas_n` is never low while `ras_n` is high. A CPU request held high is acknowledged once per access.
- R10: The sequencer enters idle only from precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 2*MA_W | CPU address: row in upper half, column in lower half |
| cpu_ack | output | 1 | One-cycle pulse when the CPU access is granted |
| xfer_req | input | 1 | One-cycle line-transfer request pulse |
| xfer_addr | input | 2*MA_W | Transfer row and start column, held until acknowledged |
| xfer_ack | output | 1 | One-cycle pulse when the transfer is granted |
| dram_addr | output | MA_W | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dt_oe_n | output | 1 | Transfer marker / output enable, active low |

## Verification
The critical collision is a line-transfer pulse and a held CPU request that are both waiting when precharge ends. Refresh expiry can land on the same decision edge. Random CPU traffic with back-to-back requests overlaps free-running transfer pulses and the refresh timer. A directed case raises a new CPU request and a transfer pulse in the same cycle, during a running access. A pin-level monitor rebuilds each RAS cycle. It judges priority from when each pulse was sampled compared with the grant edge, and it checks that the transfer is served first and that neither request is lost.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_XFER,
        ST_REFRESH,
        ST_PRECHARGE
    } arb_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_REF,
        SRC_XFER,
        SRC_CPU
    } arb_src_t;

    typedef struct packed {
        arb_src_t src;
        logic     wr;
    } cyc_kind_t;

    // fixed priority: refresh, then line transfer, then CPU
    function automatic arb_src_t pick_src(input logic ref_p, input logic xfer_p,
                                          input logic cpu_p);
        if (ref_p)       return SRC_REF;
        else if (xfer_p) return SRC_XFER;
        else if (cpu_p)  return SRC_CPU;
        else             return SRC_NONE;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/vram_refresh_timer.sv
module vram_refresh_timer #(
    parameter int REF_INTERVAL = 390,
    parameter int MA_W         = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_take,
    input  logic            ref_done,
    output logic            ref_pend,
    output logic [MA_W-1:0] ref_row
);
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            ref_pend <= tick | (ref_pend & ~ref_take);
            if (ref_done)
                ref_row <= ref_row + 1'b1;
        end
    end
endmodule

// File: rtl/vram_req_latch.sv
module vram_req_latch #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_req,
    input  logic          xfer_take,
    input  logic          cpu_take,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] xfer_addr,
    output logic          xfer_pend,
    output logic [AW-1:0] lat_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_pend <= 1'b0;
            lat_addr  <= '0;
        end else begin
            // a new pulse in the grant cycle stays pending for the next line
            xfer_pend <= xfer_req | (xfer_pend & ~xfer_take);
            if (xfer_take)
                lat_addr <= xfer_addr;
            else if (cpu_take)
                lat_addr <= cpu_addr;
        end
    end
endmodule

// File: rtl/vram_seq.sv
module vram_seq
    import vram_arb_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 3,
    parameter int T_REF_RAS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pend,
    input  logic       xfer_pend,
    input  logic       cpu_req,
    input  logic       cpu_we,
    output arb_state_t state,
    output cyc_kind_t  kind,
    output logic       ref_take,
    output logic       xfer_take,
    output logic       cpu_take,
    output logic       ref_done,
    output logic       cpu_ack,
    output logic       xfer_ack
);
    localparam int TMAX = max4(T_RCD, T_CAS, T_RP, T_REF_RAS);
    localparam int CW   = $clog2(TMAX + 1);

    logic [CW-1:0] cnt;
    arb_src_t      pick;

    assign pick      = pick_src(ref_pend, xfer_pend, cpu_req);
    assign ref_take  = (state == ST_IDLE) && (pick == SRC_REF);
    assign xfer_take = (state == ST_IDLE) && (pick == SRC_XFER);
    assign cpu_take  = (state == ST_IDLE) && (pick == SRC_CPU);
    assign ref_done  = (state == ST_REFRESH) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            kind     <= '{src: SRC_NONE, wr: 1'b0};
            cnt      <= '0;
            cpu_ack  <= 1'b0;
            xfer_ack <= 1'b0;
        end else begin
            cpu_ack  <= cpu_take;
            xfer_ack <= xfer_take;
            unique case (state)
                ST_IDLE: begin
                    if (pick != SRC_NONE) begin
                        kind.src <= pick;
                        kind.wr  <= (pick == SRC_CPU) && cpu_we;
                        if (pick == SRC_REF) begin
                            state <= ST_REFRESH;
                            cnt   <= CW'(T_REF_RAS - 1);
                        end else begin
                            state <= ST_ROW;
                            cnt   <= CW'(T_RCD - 1);
                        end
                    end
                end
                ST_ROW: begin
                    if (cnt == '0) begin
                        state <= (kind.src == SRC_XFER) ? ST_XFER : ST_COL;
                        cnt   <= CW'(T_CAS - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_COL, ST_XFER, ST_REFRESH: begin
                    if (cnt == '0) begin
                        state <= ST_PRECHARGE;
                        cnt   <= CW'(T_RP - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_PRECHARGE: begin
                    if (cnt == '0)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vram_arb_pkg::*;
#(
    parameter int MA_W         = 9,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_REF_RAS    = 3,
    parameter int REF_INTERVAL = 390
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [2*MA_W-1:0] cpu_addr,
    output logic              cpu_ack,
    input  logic              xfer_req,
    input  logic [2*MA_W-1:0] xfer_addr,
    output logic              xfer_ack,
    output logic [MA_W-1:0]   dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              dt_oe_n
);
    localparam int AW = 2 * MA_W;

    arb_state_t      state;
    cyc_kind_t       kind;
    logic            ref_pend, xfer_pend;
    logic            ref_take, xfer_take, cpu_take, ref_done;
    logic [MA_W-1:0] ref_row;
    logic [AW-1:0]   lat_addr;
    logic [MA_W-1:0] lat_row, lat_col;

    vram_refresh_timer #(.REF_INTERVAL(REF_INTERVAL), .MA_W(MA_W)) u_refresh (
        .clk(clk), .rst(rst), .ref_take(ref_take), .ref_done(ref_done),
        .ref_pend(ref_pend), .ref_row(ref_row)
    );

    vram_req_latch #(.AW(AW)) u_latch (
        .clk(clk), .rst(rst), .xfer_req(xfer_req), .xfer_take(xfer_take),
        .cpu_take(cpu_take), .cpu_addr(cpu_addr), .xfer_addr(xfer_addr),
        .xfer_pend(xfer_pend), .lat_addr(lat_addr)
    );

    vram_seq #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS)) u_seq (
        .clk(clk), .rst(rst), .ref_pend(ref_pend), .xfer_pend(xfer_pend),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .state(state), .kind(kind),
        .ref_take(ref_take), .xfer_take(xfer_take), .cpu_take(cpu_take),
        .ref_done(ref_done), .cpu_ack(cpu_ack), .xfer_ack(xfer_ack)
    );

    assign lat_row = lat_addr[AW-1:MA_W];
    assign lat_col = lat_addr[MA_W-1:0];

    always_comb begin
        ras_n   = !(state inside {ST_ROW, ST_COL, ST_XFER, ST_REFRESH});
        cas_n   = !(state inside {ST_COL, ST_XFER});
        we_n    = !((state == ST_COL) && kind.wr);
        dt_oe_n = !(((kind.src == SRC_XFER) && (state inside {ST_ROW, ST_XFER}))
                 || ((state == ST_COL) && (kind.src == SRC_CPU) && !kind.wr));
        unique case (state)
            ST_COL, ST_XFER: dram_addr = lat_col;
            ST_REFRESH:      dram_addr = ref_row;
            default:         dram_addr = lat_row;
        endcase
    end
endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk
    import vram_arb_pkg::*;
#(
    parameter int MA_W = 9,
    parameter int T_RP = 3
) (
    input logic            clk,
    input logic            rst,
    input arb_state_t      state,
    input logic            ref_pend,
    input logic            xfer_pend,
    input logic [MA_W-1:0] dram_addr,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            dt_oe_n,
    input logic            cpu_ack,
    input logic            xfer_ack
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            hi_cnt <= 8'd255;
        else if (!ras_n)
            hi_cnt <= 8'd0;
        else if (hi_cnt != 8'd255)
            hi_cnt <= hi_cnt + 8'd1;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && we_n && dt_oe_n && !cpu_ack && !xfer_ack));

    a_r2_refresh_first: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && ref_pend) |=> (state == ST_REFRESH));

    a_r2_xfer_before_cpu: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !ref_pend && xfer_pend) |=> (state == ST_ROW && xfer_ack));

    a_r3_ack_at_ras_fall: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> $fell(ras_n));

    a_r4_dt_low_at_ras_fall: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && xfer_ack) |-> !dt_oe_n);

    a_r6_precharge_time: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= 8'(T_RP)));

    a_r7_row_addr_held: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROW && $past(state) == ST_ROW) |-> $stable(dram_addr));

    a_r8_single_xfer_ack: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |=> !xfer_ack);

    a_r9_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    a_r9_we_inside_cas: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !cas_n);

    a_r10_idle_via_precharge: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) != ST_IDLE) |-> ($past(state) == ST_PRECHARGE));
endmodule

bind vram_arbiter vram_arbiter_chk #(.MA_W(MA_W), .T_RP(T_RP)) u_chk (
    .clk(clk), .rst(rst), .state(state), .ref_pend(ref_pend), .xfer_pend(xfer_pend),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dt_oe_n(dt_oe_n), .cpu_ack(cpu_ack), .xfer_ack(xfer_ack)
);

// File: tb/test_vram_arbiter.sv
`timescale 1ns/1ps
module test_vram_arbiter;
    localparam int MA_W = 8;
    localparam int AW = 2 * MA_W;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_REF_RAS = 3;
    localparam int REF_INTERVAL = 97;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0, xfer_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0, xfer_addr = '0;
    logic cpu_ack, xfer_ack, ras_n, cas_n, we_n, dt_oe_n;
    logic [MA_W-1:0] dram_addr;

    always #4 clk = ~clk;

    vram_arbiter #(.MA_W(MA_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
                   .T_REF_RAS(T_REF_RAS), .REF_INTERVAL(REF_INTERVAL)) i_vram_arbiter (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_ack(cpu_ack), .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_ack(xfer_ack),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dt_oe_n(dt_oe_n)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    logic [AW-1:0] cpu_exp = '0, xfer_exp = '0;
    logic cpu_we_exp = 1'b0;
    logic xfer_out = 1'b0;
    int xfer_edge = 0, n_pulse = 0, n_xack = 0, n_ref = 0, rst_end = 0;
    bit cpu_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [MA_W-1:0] row_of(input logic [AW-1:0] a);
        return a[AW-1:MA_W];
    endfunction
    function automatic logic [MA_W-1:0] col_of(input logic [AW-1:0] a);
        return a[MA_W-1:0];
    endfunction

    // pin-level monitor rebuilding every RAS cycle
    logic prev_ras = 1'b1;
    int gap = 100, k = 0, kindv = 0;
    logic [AW-1:0] cur_exp = '0;
    logic cur_we = 1'b0;
    logic [MA_W-1:0] ref_row_exp = '0, ref_row_cur = '0;

    always @(negedge clk) begin
        if (!rst) begin
            bit fall;
            fall = !ras_n && prev_ras;
            chk(!(ras_n && !cas_n), "R9 cas outside ras", cas_n, 1);
            if (cpu_ack) chk(fall, "R3 ack at ras fall", fall, 1);
            if (xfer_ack) chk(fall, "R4 ack at ras fall", fall, 1);
            if (fall) begin
                chk(gap >= T_RP, "R6 precharge", gap, T_RP);
                gap = 0;
                k = 0;
                if (cpu_ack) begin
                    kindv = 1;
                    cur_exp = cpu_exp;
                    cur_we = cpu_we_exp;
                    chk(!(xfer_out && xfer_edge < cyc), "R2 transfer before cpu", xfer_edge, cyc);
                end else if (xfer_ack) begin
                    kindv = 2;
                    cur_exp = xfer_exp;
                    cur_we = 1'b0;
                    chk(xfer_out, "R8 ack without pulse", xfer_out, 1);
                    chk(dt_oe_n == 1'b0, "R4 dt at ras fall", dt_oe_n, 0);
                    xfer_out = 1'b0;
                    n_xack++;
                end else begin
                    kindv = 0;
                    ref_row_cur = ref_row_exp;
                    ref_row_exp = ref_row_exp + 1'b1;
                    n_ref++;
                end
            end
            if (!ras_n) begin
                if (kindv == 0) begin
                    chk(dram_addr == ref_row_cur, "R5 refresh row", dram_addr, ref_row_cur);
                    chk(cas_n && we_n && dt_oe_n, "R5 ras-only strobes", {cas_n, we_n, dt_oe_n}, 7);
                end else if (k < T_RCD) begin
                    chk(dram_addr == row_of(cur_exp), kindv == 1 ? "R3 row / R7" : "R4 row / R7",
                        dram_addr, row_of(cur_exp));
                    chk(cas_n && we_n, "R3 row phase strobes", {cas_n, we_n}, 3);
                    chk(dt_oe_n == (kindv == 1), "R4 dt in row phase", dt_oe_n, kindv == 1);
                end else begin
                    chk(k < T_RCD + T_CAS, "R3 ras too long", k, T_RCD + T_CAS);
                    chk(!cas_n, "R3 cas low", cas_n, 0);
                    chk(dram_addr == col_of(cur_exp), kindv == 1 ? "R3 col / R7" : "R4 col / R7",
                        dram_addr, col_of(cur_exp));
                    if (kindv == 1) begin
                        chk(we_n == !cur_we, "R3 we / R7", we_n, !cur_we);
                        chk(dt_oe_n == cur_we, "R3 oe on read", dt_oe_n, cur_we);
                    end else begin
                        chk(we_n && !dt_oe_n, "R4 transfer strobes", {we_n, dt_oe_n}, 2);
                    end
                end
                k++;
            end else begin
                if (!prev_ras)
                    chk(k == ((kindv == 0) ? T_REF_RAS : T_RCD + T_CAS), "R3 R4 R5 ras length",
                        k, (kindv == 0) ? T_REF_RAS : T_RCD + T_CAS);
                gap++;
            end
        end
        prev_ras = ras_n;
    end

    task automatic cpu_access(input logic [AW-1:0] a, input logic w, input int idle);
        @(negedge clk);
        cpu_exp = a; cpu_we_exp = w;
        cpu_addr = a; cpu_we = w; cpu_req = 1'b1;
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
        cpu_addr = AW'($urandom);   // R7: scramble after grant
        cpu_we = ~w;
        repeat (idle) @(negedge clk);
    endtask

    task automatic xfer_pulse(input logic [AW-1:0] a);
        xfer_exp = a; xfer_addr = a;
        xfer_req = 1'b1; xfer_out = 1'b1; xfer_edge = cyc + 1; n_pulse++;
        @(negedge clk);
        xfer_req = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n && dt_oe_n, "R1 strobes in reset", {ras_n, cas_n, we_n, dt_oe_n}, 15);
        chk(!cpu_ack && !xfer_ack, "R1 acks in reset", {cpu_ack, xfer_ack}, 0);
        rst = 1'b0;
        rst_end = cyc;
        @(negedge clk);
        chk(ras_n && cas_n && we_n && dt_oe_n, "R1 strobes after reset", {ras_n, cas_n, we_n, dt_oe_n}, 15);
        chk(!cpu_ack && !xfer_ack, "R1 acks after reset", {cpu_ack, xfer_ack}, 0);

        // directed: write then read on boundary addresses, back to back
        cpu_access({AW{1'b1}}, 1'b1, 0);
        cpu_access('0, 1'b0, 0);

        fork
            begin : cpu_thread
                for (int i = 0; i < 300; i++) begin
                    cpu_access(AW'($urandom), 1'($urandom), ($urandom % 4 == 0) ? 0 : $urandom % 6);
                end
                cpu_done = 1;
            end
            begin : xfer_thread
                while (!cpu_done) begin
                    @(negedge clk);
                    xfer_pulse(AW'($urandom));
                    while (xfer_out) @(negedge clk);
                    @(negedge clk);
                    xfer_addr = AW'($urandom);   // R7: scramble after grant
                    repeat (5 + $urandom % 60) @(negedge clk);
                end
            end
        join

        // directed race: new CPU request and transfer pulse in the same cycle mid-access
        @(negedge clk);
        cpu_exp = 16'hA55A; cpu_we_exp = 1'b0;
        cpu_addr = 16'hA55A; cpu_we = 1'b0; cpu_req = 1'b1;
        do @(negedge clk); while (!cpu_ack);
        @(negedge clk);
        cpu_exp = 16'h3CC3; cpu_we_exp = 1'b1; cpu_addr = 16'h3CC3; cpu_we = 1'b1;
        xfer_pulse(16'h0FF0);
        do @(negedge clk); while (!xfer_ack && !cpu_ack);
        chk(xfer_ack && !cpu_ack, "R2 R8 transfer served first", {xfer_ack, cpu_ack}, 2);
        do @(negedge clk); while (!cpu_ack);
        cpu_req = 1'b0;
        repeat (30) @(negedge clk);

        chk(!xfer_out && n_pulse == n_xack, "R8 every pulse served once", n_xack, n_pulse);
        chk(n_ref >= (cyc - rst_end) / REF_INTERVAL - 1, "R5 refresh rate", n_ref,
            (cyc - rst_end) / REF_INTERVAL);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule